// File: doc/BRIEF.md
# Banked Cartridge Window Decoder

This block sits on the address, data and strobe lines of an 8-bit CPU. It serves a 16 kB cartridge window at 0x4000-0x7FFF, backed by a 128 kB flash device. The flash is split into eight 16 kB banks, and only one bank shows in the window at a time. The CPU picks the bank by writing a control byte to a fixed address inside the window. The same byte also switches on a register overlay that reaches a disk controller.

With the overlay on, two areas near the top of the window stop decoding as flash:

- **0x7C00-0x7DFF:** every address here selects the 16-bit data port. Address bit 0 tells the port which byte lane is being accessed, so a block copy can stream a whole sector through this area.
- **0x7E00-0x7EFF:** this area selects the byte-wide task-file registers. The register index comes from the four lowest address bits, so the sixteen registers repeat every 16 bytes.

The rest of the window, including 0x7F00-0x7FFF, still reads flash. The control register cannot be read back. A read at its address returns the flash byte stored there. The block does not pass writes on to the flash.

All outputs are combinational from the current bus cycle and the control register. The control register itself changes on a clock edge where a write strobe is present. The CPU bus has no valid/ready handshake: each strobe is one complete access, and the block never stalls it. Back-pressure therefore does not apply.

Top module: `cbm_mapper`

## Requirements
- R1: After reset the control register holds 0x00. This selects bank 0 with the overlay off, so a read at 0x5000 drives flash address 0x01000 with the flash select high.
- R2: A write strobe at 0x4104 loads the control register on that clock edge. Data bits 7:5 become the bank number and data bit 0 becomes the overlay enable. Data bits 4:1 have no effect.
- R3: A read at 0x4104 asserts the flash select with flash address {bank, 0x0104}, and it leaves the control register unchanged.
- R4: The 17-bit flash address is the bank number in bits 16:14 and CPU address bits 13:0 below it.
- R5: With the overlay on, any access in 0x7C00-0x7DFF asserts the data-port select, keeps the flash select low, and drives the byte-lane flag from address bit 0 (0 = low byte, 1 = high byte).
- R6: With the overlay on, any access in 0x7E00-0x7EFF asserts the task-file select with register index equal to address bits 3:0, and keeps the flash select low.
- R7: With the overlay off, a read anywhere in 0x4000-0x7FFF asserts the flash select, and neither register select is ever asserted.
- R8: With the overlay on, reads in 0x4000-0x7BFF and 0x7F00-0x7FFF still assert the flash select.
- R9: A write strobe never asserts the flash select.
- R10: Accesses outside 0x4000-0x7FFF assert no select. A write there, including one whose low 14 bits are 0x0104, leaves the control register unchanged.
- R11: Without a read or write strobe, no select is asserted. At most one of the three selects is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the control register |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| flash_addr | output | 17 | Flash byte address |
| flash_cs | output | 1 | Flash read select |
| dport_sel | output | 1 | 16-bit data port select |
| dport_hi | output | 1 | Byte lane of the data port access |
| tfile_sel | output | 1 | Task-file register select |
| tfile_idx | output | 4 | Task-file register index |

## Verification
The bank number and the overlay enable are only visible at the ports during later accesses. A wrong bank shows up in bits 16:14 of the flash address on the first read after the faulty write. A wrong overlay bit shows up as flash selected instead of a register select, or the reverse, on the first access to 0x7C00-0x7EFF. The bench reads the window after every control write, so a corrupted register is caught within one or two bus cycles. A stray load caused by a read, or by a write outside the window, is caught the same way.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_FLASH = 2'd1,
    RGN_DPORT = 2'd2,
    RGN_TFILE = 2'd3
  } region_e;
endpackage

// File: rtl/cbm_ctrl_reg.sv
module cbm_ctrl_reg #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SEG_W     = 3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h4104
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  output logic [SEG_W-1:0]  seg,
  output logic              ovl
);
  localparam int SEG_LSB = DATA_W - SEG_W;

  logic hit;
  assign hit = wr && (addr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg <= '0;
      ovl <= 1'b0;
    end else if (hit) begin
      seg <= wdata[DATA_W-1:SEG_LSB];
      ovl <= wdata[0];
    end
  end
endmodule

// File: rtl/cbm_region_decode.sv
module cbm_region_decode
  import cbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 14,
  parameter logic [ADDR_W-OFS_W-1:0] WIN_PAGE = 2'b01,
  parameter logic [ADDR_W-1:0] DPORT_LO = 16'h7C00,
  parameter logic [ADDR_W-1:0] DPORT_HI = 16'h7DFF,
  parameter logic [ADDR_W-1:0] TFILE_LO = 16'h7E00,
  parameter logic [ADDR_W-1:0] TFILE_HI = 16'h7EFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ovl,
  output region_e           rgn
);
  logic in_win, in_dp, in_tf;

  assign in_win = (addr[ADDR_W-1:OFS_W] == WIN_PAGE);
  assign in_dp  = (addr >= DPORT_LO) && (addr <= DPORT_HI);
  assign in_tf  = (addr >= TFILE_LO) && (addr <= TFILE_HI);

  always_comb begin
    rgn = RGN_NONE;
    if (in_win) begin
      if (ovl && in_dp)      rgn = RGN_DPORT;
      else if (ovl && in_tf) rgn = RGN_TFILE;
      else                   rgn = RGN_FLASH;
    end
  end
endmodule

// File: rtl/cbm_addr_map.sv
module cbm_addr_map #(
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 3,
  parameter int OFS_W  = 14,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [SEG_W-1:0]       seg,
  output logic [SEG_W+OFS_W-1:0] faddr,
  output logic [IDX_W-1:0]       idx,
  output logic                   lane
);
  genvar b;
  generate
    for (b = 0; b < OFS_W; b++) begin : g_ofs
      assign faddr[b] = addr[b];
    end
    for (b = 0; b < SEG_W; b++) begin : g_seg
      assign faddr[OFS_W+b] = seg[b];
    end
  endgenerate

  assign idx  = addr[IDX_W-1:0];
  assign lane = addr[0];
endmodule

// File: rtl/cbm_mapper.sv
module cbm_mapper
  import cbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SEG_W  = 3,
  parameter int OFS_W  = 14,
  parameter int IDX_W  = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h4104,
  localparam int FA_W  = SEG_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [FA_W-1:0]   flash_addr,
  output logic              flash_cs,
  output logic              dport_sel,
  output logic              dport_hi,
  output logic              tfile_sel,
  output logic [IDX_W-1:0]  tfile_idx
);
  logic [SEG_W-1:0] seg_q;
  logic             ovl_q;
  region_e          rgn;
  logic             access;

  cbm_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .wdata(cpu_wdata),
    .wr(cpu_wr), .seg(seg_q), .ovl(ovl_q)
  );

  cbm_region_decode #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W)
  ) u_dec (
    .addr(cpu_addr), .ovl(ovl_q), .rgn(rgn)
  );

  cbm_addr_map #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W), .OFS_W(OFS_W), .IDX_W(IDX_W)
  ) u_map (
    .addr(cpu_addr), .seg(seg_q), .faddr(flash_addr),
    .idx(tfile_idx), .lane(dport_hi)
  );

  assign access    = cpu_rd || cpu_wr;
  assign flash_cs  = cpu_rd && !cpu_wr && (rgn == RGN_FLASH);
  assign dport_sel = access && (rgn == RGN_DPORT);
  assign tfile_sel = access && (rgn == RGN_TFILE);
endmodule

// File: rtl/cbm_mapper_chk.sv
module cbm_mapper_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SEG_W  = 3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h4104
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic              flash_cs,
  input logic              dport_sel,
  input logic              tfile_sel,
  input logic [SEG_W-1:0]  seg_q,
  input logic              ovl_q
);
  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == CTRL_ADDR) |=>
      (seg_q == $past(cpu_wdata[DATA_W-1:DATA_W-SEG_W]) && ovl_q == $past(cpu_wdata[0])));

  // R3
  ctrl_read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr) |=> ($stable(seg_q) && $stable(ovl_q)));

  // R9
  no_flash_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |-> !flash_cs);

  // R10
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1:ADDR_W-2] != 2'b01) |-> !(flash_cs || dport_sel || tfile_sel));

  // R11
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flash_cs, dport_sel, tfile_sel}));

  // R8
  top_page_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_q && cpu_rd && !cpu_wr && cpu_addr[ADDR_W-1:8] == 8'h7F) |-> flash_cs);
endmodule

bind cbm_mapper cbm_mapper_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .flash_cs(flash_cs),
  .dport_sel(dport_sel), .tfile_sel(tfile_sel), .seg_q(seg_q), .ovl_q(ovl_q)
);

// File: tb/sim_cbm_mapper.sv
`timescale 1ns/1ps
module sim_cbm_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [16:0] flash_addr;
  logic        flash_cs, dport_sel, dport_hi, tfile_sel;
  logic [3:0]  tfile_idx;

  int n_run = 0;
  int n_fail = 0;
  logic [2:0] m_seg = 3'd0;
  logic       m_ovl = 1'b0;

  always #2 clk = ~clk;

  cbm_mapper u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .flash_addr(flash_addr),
    .flash_cs(flash_cs), .dport_sel(dport_sel), .dport_hi(dport_hi),
    .tfile_sel(tfile_sel), .tfile_idx(tfile_idx)
  );

  // expected selects packed as {flash, dport, tfile}
  function automatic logic [2:0] exp_sel(input logic [15:0] a, input logic rd,
                                         input logic wr, input logic ov);
    logic win, dp, tf;
    win = (a >= 16'h4000) && (a <= 16'h7FFF);
    dp  = ov && (a >= 16'h7C00) && (a <= 16'h7DFF);
    tf  = ov && (a >= 16'h7E00) && (a <= 16'h7EFF);
    if (!win || !(rd || wr)) return 3'b000;
    if (dp) return 3'b010;
    if (tf) return 3'b001;
    return (rd && !wr) ? 3'b100 : 3'b000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h act=%h exp=%h", req, cpu_addr, act, exp);
    end
  endtask

  task automatic check_bus(input string req);
    logic [2:0] e;
    e = exp_sel(cpu_addr, cpu_rd, cpu_wr, m_ovl);
    chk(req, {29'd0, flash_cs, dport_sel, tfile_sel}, {29'd0, e});
    chk("R4", {15'd0, flash_addr}, {15'd0, m_seg, cpu_addr[13:0]});
    if (e[1]) chk("R5", {31'd0, dport_hi}, {31'd0, cpu_addr[0]});
    if (e[0]) chk("R6", {28'd0, tfile_idx}, {28'd0, cpu_addr[3:0]});
  endtask

  task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic rd,
                     input logic wr, input string req);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_rd = rd; cpu_wr = wr;
    #1 check_bus(req);
    @(posedge clk);
    if (wr && a == 16'h4104) begin
      m_seg = d[7:5];
      m_ovl = d[0];
    end
    #0.5;
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h1234_5678);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus(16'h5000, 8'h00, 1'b1, 1'b0, "R1");
    chk("R1", {15'd0, flash_addr}, 32'h0000_1000);
    // R11 idle
    bus(16'h7C10, 8'h00, 1'b0, 1'b0, "R11");
    // R7 overlay off: register areas read flash
    bus(16'h7C00, 8'h00, 1'b1, 1'b0, "R7");
    bus(16'h7E07, 8'h00, 1'b1, 1'b0, "R7");
    // R2 load bank 5, overlay on, reserved bits set
    bus(16'h4104, 8'hBF, 1'b0, 1'b1, "R2");
    bus(16'h4000, 8'h00, 1'b1, 1'b0, "R2");
    chk("R2", {29'd0, flash_addr[16:14]}, 32'd5);
    // R3 read of control address
    bus(16'h4104, 8'h00, 1'b1, 1'b0, "R3");
    chk("R3", {15'd0, flash_addr}, {15'd0, 3'd5, 14'h0104});
    bus(16'h4104, 8'h00, 1'b1, 1'b0, "R3");
    chk("R3", {29'd0, flash_addr[16:14]}, 32'd5);
    // R5 / R6 / R8 boundaries
    bus(16'h7BFF, 8'h00, 1'b1, 1'b0, "R8");
    bus(16'h7C00, 8'h00, 1'b1, 1'b0, "R5");
    bus(16'h7DFF, 8'h00, 1'b0, 1'b1, "R5");
    bus(16'h7E00, 8'h00, 1'b1, 1'b0, "R6");
    bus(16'h7EF7, 8'h00, 1'b0, 1'b1, "R6");
    bus(16'h7F00, 8'h00, 1'b1, 1'b0, "R8");
    bus(16'h7FFF, 8'h00, 1'b1, 1'b0, "R8");
    // R9 write to flash area
    bus(16'h6000, 8'h55, 1'b0, 1'b1, "R9");
    // R10 writes outside the window at aliases of the control offset
    bus(16'h0104, 8'h00, 1'b0, 1'b1, "R10");
    bus(16'hC104, 8'h00, 1'b0, 1'b1, "R10");
    bus(16'h8104, 8'h00, 1'b1, 1'b0, "R10");
    bus(16'h7E00, 8'h00, 1'b1, 1'b0, "R10");
    chk("R10", {31'd0, tfile_sel}, 32'd1);
    // overlay off again
    bus(16'h4104, 8'h40, 1'b0, 1'b1, "R2");
    bus(16'h7D01, 8'h00, 1'b1, 1'b0, "R7");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      logic [3:0]  k;
      k = 4'($urandom_range(0, 15));
      d = 8'($urandom);
      case (k)
        4'd0, 4'd1: a = 16'h4104;
        4'd2, 4'd3: a = 16'h7C00 | 16'($urandom_range(0, 16'h03FF));
        4'd4:       a = 16'($urandom);
        default:    a = 16'h4000 | 16'($urandom_range(0, 16'h3FFF));
      endcase
      if ($urandom_range(0, 3) == 0) bus(a, d, 1'b0, 1'b1, "R2");
      else                           bus(a, d, 1'b1, 1'b0, "R4");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule